// File: doc/BRIEF.md
# Clock Digit Opacity Image Streamer

This block renders a time of day as a raster of character glyphs and sends it out as 8-bit opacity pixels on an AXI4-Stream master. A local font buffer holds eleven glyphs, the ten decimal digits and a colon, with each pixel stored as a 4-bit opacity nibble. Software or a loader fills the buffer through a plain write port while the block is in load mode. In output mode, a start pulse captures the time word and the layout choice, and one frame follows.

Each two-digit time field is split into a tens glyph and a units glyph. Colons separate the fields. The short layout shows hours, minutes and seconds as eight characters. The long layout adds centiseconds and is eleven characters wide. Each row of the frame is made by placing the same glyph row of every character side by side, from left to right, and rows are sent from top to bottom. Each nibble is widened to a byte by placing the nibble in the upper half and filling the lower half with ones. A downstream mixer can then use the byte directly as an alpha value. Glyph height and width are parameters: a full-size font is 240 by 160, and a small font keeps tests short.

Top module: `clockDigitStreamer`

## Requirements
- R1: After reset, tValid and done are low, and the block is idle.
- R2: While outputMode is 0, a write with fontWrEn stores fontWrNib at fontWrAddr, where the address is glyph*GLYPH_ROWS*GLYPH_COLS + row*GLYPH_COLS + col. Glyphs 0 to 9 are the digits and glyph 10 is the colon. While outputMode is 1, writes are ignored.
- R3: A start pulse is accepted only when outputMode is 1 and the block is idle. timeIn and longFormat are captured at that moment. Later changes to them, and start pulses during a frame, do not affect the frame. A start pulse in load mode produces no output.
- R4: timeIn carries binary fields 0 to 99: hours in [31:24], minutes in [23:16], seconds in [15:8] and centiseconds in [7:0]. Character positions run hours tens, hours units, colon, minutes tens, minutes units, colon, seconds tens, seconds units. When longFormat is 1, they continue with colon, centiseconds tens and centiseconds units.
- R5: A frame is GLYPH_ROWS*GLYPH_COLS*N beats long, with N = 8 or 11. Beats are sent row by row. Within a row they are sent character by character, and within a character column by column.
- R6: Each data byte is {nibble, 4'hF}.
- R7: tUser is high on the first beat of a frame only. tLast is high on the last beat only.
- R8: While tValid is high and tReady is low, tValid, tData, tUser and tLast hold their values. No beat is lost or repeated.
- R9: done is high for exactly one cycle, in the cycle after the last beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| outputMode | input | 1 | 0: font load, 1: image output |
| fontWrEn | input | 1 | Font buffer write strobe |
| fontWrAddr | input | ADDR_W | Font buffer write address |
| fontWrNib | input | 4 | Opacity nibble to store |
| start | input | 1 | Frame start pulse |
| longFormat | input | 1 | 0: 8 characters, 1: 11 characters |
| timeIn | input | 32 | Hours, minutes, seconds and centiseconds fields |
| tReady | input | 1 | Stream ready from the sink |
| tValid | output | 1 | Stream beat valid |
| tData | output | 8 | Expanded opacity pixel |
| tUser | output | 1 | First beat of a frame |
| tLast | output | 1 | Last beat of a frame |
| done | output | 1 | One-cycle frame-complete pulse |

## Verification
The embedded assertions check the following on every cycle:
- a stalled beat stays frozen until it is accepted;
- every valid byte ends in a filled low nibble;
- done only ever follows an accepted final beat;
- a start pulse in load mode leaves the block idle.

Only the bench scenarios can show the rest:
- that the right glyph lands at each character position for each time value and each layout;
- that the raster order and frame length are correct;
- that a changed time word, an extra start pulse or a font write during a frame leaves the picture untouched.

// File: rtl/clockDigitPkg.sv
package clockDigitPkg;

  typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_DRAIN} phase_t;

  typedef struct packed {
    logic snap;
    logic load;
    logic first;
    logic last;
  } ctrlStrobes_t;

  localparam logic [3:0] COLON_GLYPH = 4'd10;

  function automatic logic [3:0] tensOf(input logic [7:0] v);
    return 4'(v / 8'd10);
  endfunction

  function automatic logic [3:0] unitsOf(input logic [7:0] v);
    return 4'(v % 8'd10);
  endfunction

  // Glyph index shown at a character position for a captured time word.
  function automatic logic [3:0] glyphFor(input logic [3:0] pos, input logic [31:0] t);
    case (pos)
      4'd0:    return tensOf(t[31:24]);
      4'd1:    return unitsOf(t[31:24]);
      4'd3:    return tensOf(t[23:16]);
      4'd4:    return unitsOf(t[23:16]);
      4'd6:    return tensOf(t[15:8]);
      4'd7:    return unitsOf(t[15:8]);
      4'd9:    return tensOf(t[7:0]);
      4'd10:   return unitsOf(t[7:0]);
      default: return COLON_GLYPH;
    endcase
  endfunction

endpackage

// File: rtl/clockDigitCtrl.sv
module clockDigitCtrl
  import clockDigitPkg::*;
#(
  parameter int GLYPH_ROWS = 12,
  parameter int GLYPH_COLS = 8,
  localparam int ROW_W = $clog2(GLYPH_ROWS > 1 ? GLYPH_ROWS : 2),
  localparam int COL_W = $clog2(GLYPH_COLS > 1 ? GLYPH_COLS : 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             outputMode,
  input  logic             start,
  input  logic             longFormat,
  input  logic             tReady,
  input  logic             outValid,
  input  logic             outLast,
  output ctrlStrobes_t     strobes,
  output logic [ROW_W-1:0] rowIdx,
  output logic [3:0]       chrIdx,
  output logic [COL_W-1:0] colIdx,
  output logic             done
);

  phase_t phase;
  logic   fmtLong;
  logic   advance;
  logic   lastPos;
  logic   lastCol;
  logic   lastChr;
  logic   accept;

  assign accept  = outValid && tReady;
  assign lastCol = (colIdx == COL_W'(GLYPH_COLS - 1));
  assign lastChr = (chrIdx == (fmtLong ? 4'd10 : 4'd7));
  assign lastPos = lastCol && lastChr && (rowIdx == ROW_W'(GLYPH_ROWS - 1));
  assign advance = (phase == PH_RUN) && (!outValid || tReady);

  always_comb begin
    strobes       = '0;
    strobes.snap  = (phase == PH_IDLE) && start && outputMode;
    strobes.load  = advance;
    strobes.first = (rowIdx == '0) && (chrIdx == '0) && (colIdx == '0);
    strobes.last  = lastPos;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      fmtLong <= 1'b0;
      rowIdx  <= '0;
      chrIdx  <= '0;
      colIdx  <= '0;
      done    <= 1'b0;
    end else begin
      done <= (phase == PH_DRAIN) && accept;
      case (phase)
        PH_IDLE: begin
          if (strobes.snap) begin
            fmtLong <= longFormat;
            rowIdx  <= '0;
            chrIdx  <= '0;
            colIdx  <= '0;
            phase   <= PH_RUN;
          end
        end
        PH_RUN: begin
          if (advance) begin
            if (lastPos) begin
              phase <= PH_DRAIN;
            end else if (!lastCol) begin
              colIdx <= colIdx + 1'b1;
            end else begin
              colIdx <= '0;
              if (!lastChr) begin
                chrIdx <= chrIdx + 1'b1;
              end else begin
                chrIdx <= '0;
                rowIdx <= rowIdx + 1'b1;
              end
            end
          end
        end
        PH_DRAIN: begin
          if (accept) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(outValid && tReady && outLast));

  assert_load_mode_no_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE) && start && !outputMode |=> (phase == PH_IDLE));

endmodule

// File: rtl/clockDigitData.sv
module clockDigitData
  import clockDigitPkg::*;
#(
  parameter int GLYPH_ROWS = 12,
  parameter int GLYPH_COLS = 8,
  localparam int GLYPH_PIX  = GLYPH_ROWS * GLYPH_COLS,
  localparam int FONT_DEPTH = 11 * GLYPH_PIX,
  localparam int ADDR_W     = $clog2(FONT_DEPTH),
  localparam int ROW_W      = $clog2(GLYPH_ROWS > 1 ? GLYPH_ROWS : 2),
  localparam int COL_W      = $clog2(GLYPH_COLS > 1 ? GLYPH_COLS : 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              outputMode,
  input  logic              fontWrEn,
  input  logic [ADDR_W-1:0] fontWrAddr,
  input  logic [3:0]        fontWrNib,
  input  logic [31:0]       timeIn,
  input  ctrlStrobes_t      strobes,
  input  logic [ROW_W-1:0]  rowIdx,
  input  logic [3:0]        chrIdx,
  input  logic [COL_W-1:0]  colIdx,
  input  logic              tReady,
  output logic              tValid,
  output logic [7:0]        tData,
  output logic              tUser,
  output logic              tLast
);

  logic [3:0]        fontMem [FONT_DEPTH];
  logic [31:0]       timeHeld;
  logic [3:0]        glyph;
  logic [ADDR_W-1:0] rdAddr;
  logic [3:0]        rdNib;
  int                rdAddrInt;

  always_ff @(posedge clk) begin
    if (fontWrEn && !outputMode) fontMem[fontWrAddr] <= fontWrNib;
  end

  always_comb begin
    glyph     = glyphFor(chrIdx, timeHeld);
    rdAddrInt = int'(glyph) * GLYPH_PIX + int'(rowIdx) * GLYPH_COLS + int'(colIdx);
    rdAddr    = ADDR_W'(rdAddrInt);
    rdNib     = fontMem[rdAddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timeHeld <= '0;
      tValid   <= 1'b0;
      tData    <= '0;
      tUser    <= 1'b0;
      tLast    <= 1'b0;
    end else begin
      if (strobes.snap) timeHeld <= timeIn;
      if (strobes.load) begin
        tValid <= 1'b1;
        tData  <= {rdNib, 4'hF};
        tUser  <= strobes.first;
        tLast  <= strobes.last;
      end else if (tReady) begin
        tValid <= 1'b0;
      end
    end
  end

  assert_hold_under_stall_R8: assert property (@(posedge clk) disable iff (!rstN)
    tValid && !tReady |=> tValid && $stable(tData) && $stable(tUser) && $stable(tLast));

  assert_low_nibble_filled_R6: assert property (@(posedge clk) disable iff (!rstN)
    tValid |-> (tData[3:0] == 4'hF));

endmodule

// File: rtl/clockDigitStreamer.sv
module clockDigitStreamer
  import clockDigitPkg::*;
#(
  parameter int GLYPH_ROWS = 12,
  parameter int GLYPH_COLS = 8,
  localparam int ADDR_W = $clog2(11 * GLYPH_ROWS * GLYPH_COLS),
  localparam int ROW_W  = $clog2(GLYPH_ROWS > 1 ? GLYPH_ROWS : 2),
  localparam int COL_W  = $clog2(GLYPH_COLS > 1 ? GLYPH_COLS : 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              outputMode,
  input  logic              fontWrEn,
  input  logic [ADDR_W-1:0] fontWrAddr,
  input  logic [3:0]        fontWrNib,
  input  logic              start,
  input  logic              longFormat,
  input  logic [31:0]       timeIn,
  input  logic              tReady,
  output logic              tValid,
  output logic [7:0]        tData,
  output logic              tUser,
  output logic              tLast,
  output logic              done
);

  ctrlStrobes_t     strobes;
  logic [ROW_W-1:0] rowIdx;
  logic [3:0]       chrIdx;
  logic [COL_W-1:0] colIdx;

  clockDigitCtrl #(.GLYPH_ROWS(GLYPH_ROWS), .GLYPH_COLS(GLYPH_COLS)) u_ctrl (
    .clk(clk), .rstN(rstN), .outputMode(outputMode), .start(start),
    .longFormat(longFormat), .tReady(tReady), .outValid(tValid), .outLast(tLast),
    .strobes(strobes), .rowIdx(rowIdx), .chrIdx(chrIdx), .colIdx(colIdx), .done(done)
  );

  clockDigitData #(.GLYPH_ROWS(GLYPH_ROWS), .GLYPH_COLS(GLYPH_COLS)) u_data (
    .clk(clk), .rstN(rstN), .outputMode(outputMode), .fontWrEn(fontWrEn),
    .fontWrAddr(fontWrAddr), .fontWrNib(fontWrNib), .timeIn(timeIn),
    .strobes(strobes), .rowIdx(rowIdx), .chrIdx(chrIdx), .colIdx(colIdx),
    .tReady(tReady), .tValid(tValid), .tData(tData), .tUser(tUser), .tLast(tLast)
  );

endmodule

// File: tb/clockDigitStreamer_tb.sv
`timescale 1ns/1ps
module clockDigitStreamer_tb;

  localparam int ROWS   = 12;
  localparam int COLS   = 8;
  localparam int PIX    = ROWS * COLS;
  localparam int ADDR_W = $clog2(11 * PIX);

  // {readyPattern[1:0], longFormat, timeIn}
  localparam logic [34:0] VEC [5] = '{
    {2'd0, 1'b0, 32'h17_3B_3B_63},   // 23:59:59
    {2'd1, 1'b1, 32'h00_00_00_00},   // 00:00:00:00
    {2'd2, 1'b1, 32'h0C_22_38_4E},   // 12:34:56:78
    {2'd1, 1'b0, 32'h09_05_07_01},   // 09:05:07
    {2'd2, 1'b1, 32'h0A_14_1E_28}    // 10:20:30:40
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic outputMode = 1'b0;
  logic fontWrEn = 1'b0;
  logic [ADDR_W-1:0] fontWrAddr = '0;
  logic [3:0] fontWrNib = '0;
  logic start = 1'b0;
  logic longFormat = 1'b0;
  logic [31:0] timeIn = '0;
  logic tReady = 1'b0;
  logic tValid, tUser, tLast, done;
  logic [7:0] tData;

  int nChecks = 0;
  int nFails = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  clockDigitStreamer #(.GLYPH_ROWS(ROWS), .GLYPH_COLS(COLS)) u_dut (
    .clk(clk), .rstN(rstN), .outputMode(outputMode), .fontWrEn(fontWrEn),
    .fontWrAddr(fontWrAddr), .fontWrNib(fontWrNib), .start(start),
    .longFormat(longFormat), .timeIn(timeIn), .tReady(tReady), .tValid(tValid),
    .tData(tData), .tUser(tUser), .tLast(tLast), .done(done)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int refNib(int g, int r, int c);
    return (g * 5 + r * 3 + c * 7 + 1) % 16;
  endfunction

  function automatic int refGlyph(int p, logic [31:0] t);
    int hh = int'(t[31:24]);
    int mm = int'(t[23:16]);
    int ss = int'(t[15:8]);
    int cc = int'(t[7:0]);
    case (p)
      0: return hh / 10;  1: return hh % 10;
      3: return mm / 10;  4: return mm % 10;
      6: return ss / 10;  7: return ss % 10;
      9: return cc / 10;  10: return cc % 10;
      default: return 10;
    endcase
  endfunction

  function automatic bit readyAt(int pat, int c);
    case (pat)
      0: return 1'b1;
      1: return (c % 3) != 0;
      default: return (c % 7) < 3;
    endcase
  endfunction

  // Run one frame and check it beat by beat; optional disturbances mid-frame.
  task automatic runFrame(input logic [31:0] t, input bit fmt, input int pat, input bit disturb);
    int nChr = fmt ? 11 : 8;
    int expN = PIX * nChr;
    int beat = 0;
    int dataBad = 0, userBad = 0, lastBad = 0, holdBad = 0, doneEarly = 0;
    int lastAct = 0, lastExp = 0;
    int waited = 0;
    bit held = 0;
    logic [9:0] heldVal = '0;
    @(negedge clk);
    start = 1'b1; timeIn = t; longFormat = fmt; tReady = 1'b0;
    @(negedge clk);
    start = 1'b0; timeIn = 32'h3A_3A_3A_3A; longFormat = ~fmt;
    while (beat < expN && waited < 20000) begin
      @(negedge clk);
      waited++; cyc++;
      if (held && !(tValid && {tData, tUser, tLast} == heldVal)) holdBad++;
      if (done) doneEarly++;
      tReady = readyAt(pat, cyc);
      start = 1'b0; fontWrEn = 1'b0;
      if (disturb && waited == 20) begin
        start = 1'b1; timeIn = 32'h01_01_01_01;
        fontWrEn = 1'b1; fontWrAddr = ADDR_W'(PIX - 1); fontWrNib = 4'(~refNib(0, ROWS - 1, COLS - 1));
      end
      #1;
      held = tValid && !tReady;
      heldVal = {tData, tUser, tLast};
      if (tValid && tReady) begin
        int r = beat / (COLS * nChr);
        int rem = beat % (COLS * nChr);
        int p = rem / COLS;
        int c = rem % COLS;
        int expD = refNib(refGlyph(p, t), r, c) * 16 + 15;
        if (int'(tData) != expD) begin
          if (dataBad == 0) begin lastAct = int'(tData); lastExp = expD; end
          dataBad++;
        end
        if (tUser != (beat == 0)) userBad++;
        if (tLast != (beat == expN - 1)) lastBad++;
        beat++;
      end
    end
    start = 1'b0; fontWrEn = 1'b0;
    check(waited < 20000, "watchdog frame R5", waited, 20000);
    check(dataBad == 0, "glyph pixels R4 R5 R6 first mismatch", lastAct, lastExp);
    check(userBad == 0, "tUser placement R7", userBad, 0);
    check(lastBad == 0, "tLast placement R7", lastBad, 0);
    check(holdBad == 0, "stall hold R8", holdBad, 0);
    check(doneEarly == 0, "done before end R9", doneEarly, 0);
    @(negedge clk);
    check(done == 1'b1, "done pulse R9", done, 1);
    check(tValid == 1'b0, "frame length R5", tValid, 0);
    @(negedge clk);
    check(done == 1'b0, "done single cycle R9", done, 0);
    check(tValid == 1'b0, "no extra frame R3", tValid, 0);
    tReady = 1'b0;
  endtask

  initial begin
    #1500000;
    nFails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(tValid == 1'b0, "reset tValid R1", tValid, 0);
    check(done == 1'b0, "reset done R1", done, 0);

    // R2: font load in load mode
    for (int g = 0; g < 11; g++)
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++) begin
          @(negedge clk);
          fontWrEn = 1'b1;
          fontWrAddr = ADDR_W'(g * PIX + r * COLS + c);
          fontWrNib = 4'(refNib(g, r, c));
        end
    @(negedge clk);
    fontWrEn = 1'b0;

    // R3: start in load mode yields nothing
    start = 1'b1; timeIn = 32'h01_02_03_04; tReady = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    check(tValid == 1'b0, "start ignored in load mode R3", tValid, 0);
    tReady = 1'b0;

    outputMode = 1'b1;
    for (int i = 0; i < 5; i++)
      runFrame(VEC[i][31:0], VEC[i][32], int'(VEC[i][34:33]), 1'b0);

    // R2 R3: mid-frame start, time change and font write all ignored
    runFrame(32'h00_00_00_00, 1'b0, 1, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule